// File: doc/BRIEF.md
# Release-Consistency L1 Cache Controller

This block is a direct-mapped, write-back, write-allocate L1 controller for one streaming core. It makes the core's memory accesses coherent with other cores by enforcing release consistency itself, not by keeping a single-writer invariant. The L2 behind it keeps no sharer or owner information and may drop blocks silently. All coherence work is therefore done locally, at synchronization points. A release that covers the whole device pushes every dirty line out to the L2 before its own store is published. An acquire that covers the whole device pulls a fresh copy of its block from the L2 and then discards every other line, so later loads cannot return stale data.

Each core request carries a two-bit kind (`00` load, `01` store, `10` acquire load, `11` release store) and a scope bit (`1` = device-wide or unscoped, `0` = thread-group). Synchronization with thread-group scope needs no coherence work, because the threads it covers already share this L1. The controller handles such requests exactly like a plain load or store. Lines hold one data word, so a store miss allocates its line without fetching it. The core is stalled from the cycle a request is accepted until its one-cycle response.

The controller is a single state machine with these states:
- IDLE: accepts a request.
- DISPATCH: classifies the request.
- EVICT: writes back a dirty victim.
- FILL: reads the requested block from the L2.
- ACCESS: performs the local read or write.
- FLUSH: walks the lines for a release.
- INV: walks the lines for an acquire.
- RELWB: publishes the release line.
- RESP: returns the response.

Its transitions are:
- IDLE to DISPATCH when a request is valid.
- DISPATCH to FLUSH for a device-wide release.
- DISPATCH to EVICT or FILL for a device-wide acquire, depending on whether the indexed line is dirty.
- DISPATCH to ACCESS on a hit, or on a store miss with a clean victim.
- DISPATCH to EVICT on a miss with a dirty victim.
- DISPATCH to FILL on a load miss with a clean victim.
- EVICT to ACCESS (stores) or to FILL (loads and acquires) on the L2 acknowledge.
- FILL to INV (device-wide acquire) or to ACCESS on the L2 acknowledge.
- FLUSH to ACCESS after the last index.
- ACCESS to RELWB (device-wide release) or to RESP.
- INV to RESP after the last index.
- RELWB to RESP on the L2 acknowledge.
- RESP to IDLE.

Top module: `l1rc`

## Requirements
- R1: After reset the controller is ready, issues no response and no L2 request, and every line is invalid, so the first load of any address fetches it from the L2.
- R2: A plain load that hits returns the cached word with no L2 traffic. A plain load that misses issues one L2 read at the request address and returns the L2's word.
- R3: A plain store writes the word locally and marks the line dirty, with no L2 traffic on a hit or on a miss whose victim is clean. A later load of that address returns the stored word.
- R4: A miss whose indexed line is valid and dirty first writes that victim back to the L2 at the victim's own address, and only then issues the read for a load miss.
- R5: A device-wide release (kind `11`, scope `1`) writes back every dirty line in ascending index order, one L2 write each. It then stores its word and writes its own line back as the last L2 write, and responds only after that write is acknowledged.
- R6: A device-wide acquire (kind `10`, scope `1`) always reads its block from the L2, even when the block is present, and returns the L2's word. Afterwards every other line is invalid and the acquired block stays cached.
- R7: During an acquire's invalidation walk, a dirty line other than the acquired one is written back to the L2 before it is dropped. A dirty copy of the acquired block itself is written back before the fresh read.
- R8: An acquire or release with thread-group scope (scope `0`) behaves exactly as a plain load or store: no flush, no invalidation, and no L2 traffic on a hit.
- R9: The ready output is low from the cycle after a request is accepted until the response. The response valid output is high for exactly one cycle per request.
- R10: Once the L2 request valid is raised, it and the request address, direction and write data stay unchanged until the cycle the L2 acknowledges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_req_valid | input | 1 | Core request present (taken when ready is high) |
| core_req_ready | output | 1 | Controller idle and able to take a request |
| core_req_kind | input | 2 | 00 load, 01 store, 10 acquire load, 11 release store |
| core_req_gpu | input | 1 | 1 = device-wide or unscoped, 0 = thread-group scope |
| core_req_addr | input | ADDR_W | Word address |
| core_req_wdata | input | DATA_W | Store data |
| core_rsp_valid | output | 1 | One-cycle completion pulse |
| core_rsp_rdata | output | DATA_W | Load result, valid with the response pulse |
| l2_req_valid | output | 1 | L2 request present, held until acknowledged |
| l2_req_write | output | 1 | 1 = write-back, 0 = read |
| l2_req_addr | output | ADDR_W | Block address |
| l2_req_wdata | output | DATA_W | Write-back data |
| l2_ack | input | 1 | L2 acknowledges the current request |
| l2_rdata | input | DATA_W | Read data, valid with the acknowledge |

## Verification
The assertions assume the following about the core and the L2:
- The core offers a request only while ready is high.
- The L2 raises its acknowledge only while a request is outstanding, and drops it in the next cycle.
- The L2 returns read data in the same cycle as the acknowledge.

The bench's L2 model answers each request after a fixed two-cycle wait and then deasserts its acknowledge. The core driver waits for ready before raising a request for a single cycle. Within those limits, the stimulus runs every address through miss and hit loads. It then builds known sets of dirty and clean lines before each release and acquire, so the order and content of every L2 transfer can be predicted.

// File: rtl/l1rc_pkg.sv
package l1rc_pkg;

    // bit 0 of the kind marks a request that writes the cache
    typedef enum logic [1:0] {
        K_LOAD  = 2'b00,
        K_STORE = 2'b01,
        K_ACQ   = 2'b10,
        K_REL   = 2'b11
    } kind_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_DISPATCH,
        S_EVICT,
        S_FILL,
        S_ACCESS,
        S_FLUSH,
        S_INV,
        S_RELWB,
        S_RESP
    } state_e;

endpackage

// File: rtl/l1rc_lines.sv
module l1rc_lines #(
    parameter int NUM_LINES = 16,
    parameter int TAG_W     = 4,
    parameter int DATA_W    = 32,
    localparam int IDX_W    = $clog2(NUM_LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic              rd_dirty,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_valid,
    input  logic              wr_dirty,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data,
    output logic [NUM_LINES-1:0] valid_vec,
    output logic [NUM_LINES-1:0] dirty_vec
);

    logic [TAG_W-1:0]  tag_arr  [NUM_LINES];
    logic [DATA_W-1:0] data_arr [NUM_LINES];

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        logic              v_q;
        logic              d_q;
        logic [TAG_W-1:0]  t_q;
        logic [DATA_W-1:0] w_q;
        logic              sel;

        assign sel = wr_en && (wr_idx == IDX_W'(i));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                v_q <= 1'b0;
                d_q <= 1'b0;
            end else if (sel) begin
                v_q <= wr_valid;
                d_q <= wr_dirty;
            end
        end

        always_ff @(posedge clk) begin
            if (sel) begin
                t_q <= wr_tag;
                w_q <= wr_data;
            end
        end

        assign valid_vec[i] = v_q;
        assign dirty_vec[i] = d_q;
        assign tag_arr[i]   = t_q;
        assign data_arr[i]  = w_q;
    end

    assign rd_valid = valid_vec[rd_idx];
    assign rd_dirty = dirty_vec[rd_idx];
    assign rd_tag   = tag_arr[rd_idx];
    assign rd_data  = data_arr[rd_idx];

    AST_DIRTY_IMPLIES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (dirty_vec & ~valid_vec) == '0); // R3

endmodule

// File: rtl/l1rc_fsm.sv
module l1rc_fsm
    import l1rc_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32,
    parameter int NUM_LINES = 16,
    localparam int IDX_W    = $clog2(NUM_LINES),
    localparam int TAG_W    = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              core_req_valid,
    output logic              core_req_ready,
    input  logic [1:0]        core_req_kind,
    input  logic              core_req_gpu,
    input  logic [ADDR_W-1:0] core_req_addr,
    input  logic [DATA_W-1:0] core_req_wdata,
    output logic              core_rsp_valid,
    output logic [DATA_W-1:0] core_rsp_rdata,
    output logic              l2_req_valid,
    output logic              l2_req_write,
    output logic [ADDR_W-1:0] l2_req_addr,
    output logic [DATA_W-1:0] l2_req_wdata,
    input  logic              l2_ack,
    input  logic [DATA_W-1:0] l2_rdata,
    output logic [IDX_W-1:0]  ln_rd_idx,
    input  logic              ln_valid,
    input  logic              ln_dirty,
    input  logic [TAG_W-1:0]  ln_tag,
    input  logic [DATA_W-1:0] ln_data,
    output logic              ln_wr_en,
    output logic [IDX_W-1:0]  ln_wr_idx,
    output logic              ln_wr_valid,
    output logic              ln_wr_dirty,
    output logic [TAG_W-1:0]  ln_wr_tag,
    output logic [DATA_W-1:0] ln_wr_data,
    input  logic [NUM_LINES-1:0] ln_valid_vec,
    input  logic [NUM_LINES-1:0] ln_dirty_vec
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_LINES - 1);

    state_e             state_q, state_d;
    kind_e              kind_q;
    logic               gpu_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [DATA_W-1:0]  wdata_q;
    logic [IDX_W-1:0]   sweep_q;

    logic [IDX_W-1:0]   q_idx;
    logic [TAG_W-1:0]   q_tag;
    logic               is_write, gpu_acq, gpu_rel, sweeping;
    logic               hit, victim_dirty, sweep_last;
    logic               inv_skip, inv_wb, sweep_step;

    assign q_idx        = addr_q[IDX_W-1:0];
    assign q_tag        = addr_q[ADDR_W-1:IDX_W];
    assign is_write     = kind_q[0];
    assign gpu_acq      = (kind_q == K_ACQ) && gpu_q;
    assign gpu_rel      = (kind_q == K_REL) && gpu_q;
    assign sweeping     = (state_q == S_FLUSH) || (state_q == S_INV);
    assign ln_rd_idx    = sweeping ? sweep_q : q_idx;
    assign hit          = ln_valid && (ln_tag == q_tag);
    assign victim_dirty = ln_valid && ln_dirty;
    assign sweep_last   = (sweep_q == LAST_IDX);
    assign inv_skip     = (sweep_q == q_idx);
    assign inv_wb       = !inv_skip && victim_dirty;
    assign sweep_step   = (state_q == S_FLUSH) ? (!victim_dirty || l2_ack)
                                               : (!inv_wb || l2_ack);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // request capture and walk index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q  <= K_LOAD;
            gpu_q   <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            sweep_q <= '0;
        end else begin
            if (state_q == S_IDLE && core_req_valid) begin
                kind_q  <= kind_e'(core_req_kind);
                gpu_q   <= core_req_gpu;
                addr_q  <= core_req_addr;
                wdata_q <= core_req_wdata;
            end
            if (!sweeping)                      sweep_q <= '0;
            else if (sweep_step && !sweep_last) sweep_q <= sweep_q + 1'b1;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:     if (core_req_valid) state_d = S_DISPATCH;
            S_DISPATCH: begin
                if (gpu_rel)           state_d = S_FLUSH;
                else if (gpu_acq)      state_d = victim_dirty ? S_EVICT : S_FILL;
                else if (hit)          state_d = S_ACCESS;
                else if (victim_dirty) state_d = S_EVICT;
                else if (is_write)     state_d = S_ACCESS;
                else                   state_d = S_FILL;
            end
            S_EVICT:  if (l2_ack) state_d = is_write ? S_ACCESS : S_FILL;
            S_FILL:   if (l2_ack) state_d = gpu_acq ? S_INV : S_ACCESS;
            S_ACCESS: state_d = gpu_rel ? S_RELWB : S_RESP;
            S_FLUSH:  if (sweep_step && sweep_last) state_d = S_ACCESS;
            S_INV:    if (sweep_step && sweep_last) state_d = S_RESP;
            S_RELWB:  if (l2_ack) state_d = S_RESP;
            S_RESP:   state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // outputs and line updates
    always_comb begin
        core_req_ready = (state_q == S_IDLE);
        core_rsp_valid = (state_q == S_RESP);
        core_rsp_rdata = ln_data;
        l2_req_valid   = 1'b0;
        l2_req_write   = 1'b0;
        l2_req_addr    = '0;
        l2_req_wdata   = '0;
        ln_wr_en       = 1'b0;
        ln_wr_idx      = ln_rd_idx;
        ln_wr_valid    = ln_valid;
        ln_wr_dirty    = 1'b0;
        ln_wr_tag      = ln_tag;
        ln_wr_data     = ln_data;
        unique case (state_q)
            S_EVICT: begin
                l2_req_valid = 1'b1;
                l2_req_write = 1'b1;
                l2_req_addr  = {ln_tag, q_idx};
                l2_req_wdata = ln_data;
                ln_wr_en     = l2_ack;
            end
            S_FILL: begin
                l2_req_valid = 1'b1;
                l2_req_addr  = addr_q;
                ln_wr_en     = l2_ack;
                ln_wr_valid  = 1'b1;
                ln_wr_tag    = q_tag;
                ln_wr_data   = l2_rdata;
            end
            S_ACCESS: begin
                ln_wr_en    = is_write;
                ln_wr_valid = 1'b1;
                ln_wr_dirty = 1'b1;
                ln_wr_tag   = q_tag;
                ln_wr_data  = wdata_q;
            end
            S_FLUSH: begin
                l2_req_valid = victim_dirty;
                l2_req_write = 1'b1;
                l2_req_addr  = {ln_tag, sweep_q};
                l2_req_wdata = ln_data;
                ln_wr_en     = victim_dirty && l2_ack;
            end
            S_INV: begin
                l2_req_valid = inv_wb;
                l2_req_write = 1'b1;
                l2_req_addr  = {ln_tag, sweep_q};
                l2_req_wdata = ln_data;
                ln_wr_en     = !inv_skip && ln_valid && (!ln_dirty || l2_ack);
                ln_wr_valid  = 1'b0;
            end
            S_RELWB: begin
                l2_req_valid = 1'b1;
                l2_req_write = 1'b1;
                l2_req_addr  = addr_q;
                l2_req_wdata = ln_data;
                ln_wr_en     = l2_ack;
            end
            default: ;
        endcase
    end

    AST_L2_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        l2_req_valid && !l2_ack |=> l2_req_valid && $stable(l2_req_addr)
            && $stable(l2_req_write) && $stable(l2_req_wdata)); // R10
    AST_RELEASE_AFTER_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ACCESS) && gpu_rel |-> (ln_dirty_vec == '0)); // R5
    AST_ACQUIRE_LEAVES_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RESP) && gpu_acq |-> ($countones(ln_valid_vec) == 1)
            && (ln_dirty_vec == '0)); // R6
    AST_STALL_DURING_L2: assert property (@(posedge clk) disable iff (!rst_n)
        l2_req_valid |-> !core_req_ready); // R9
    AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        core_rsp_valid |=> !core_rsp_valid && core_req_ready); // R9
    AST_LOCAL_HIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DISPATCH) && !gpu_q && hit |=> !l2_req_valid); // R8

endmodule

// File: rtl/l1rc.sv
module l1rc #(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32,
    parameter int NUM_LINES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              core_req_valid,
    output logic              core_req_ready,
    input  logic [1:0]        core_req_kind,
    input  logic              core_req_gpu,
    input  logic [ADDR_W-1:0] core_req_addr,
    input  logic [DATA_W-1:0] core_req_wdata,
    output logic              core_rsp_valid,
    output logic [DATA_W-1:0] core_rsp_rdata,
    output logic              l2_req_valid,
    output logic              l2_req_write,
    output logic [ADDR_W-1:0] l2_req_addr,
    output logic [DATA_W-1:0] l2_req_wdata,
    input  logic              l2_ack,
    input  logic [DATA_W-1:0] l2_rdata
);

    localparam int IDX_W = $clog2(NUM_LINES);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [IDX_W-1:0]     rd_idx, wr_idx;
    logic                 rd_valid, rd_dirty, wr_en, wr_valid, wr_dirty;
    logic [TAG_W-1:0]     rd_tag, wr_tag;
    logic [DATA_W-1:0]    rd_data, wr_data;
    logic [NUM_LINES-1:0] valid_vec, dirty_vec;

    l1rc_fsm #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .NUM_LINES (NUM_LINES)
    ) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .core_req_valid (core_req_valid),
        .core_req_ready (core_req_ready),
        .core_req_kind  (core_req_kind),
        .core_req_gpu   (core_req_gpu),
        .core_req_addr  (core_req_addr),
        .core_req_wdata (core_req_wdata),
        .core_rsp_valid (core_rsp_valid),
        .core_rsp_rdata (core_rsp_rdata),
        .l2_req_valid   (l2_req_valid),
        .l2_req_write   (l2_req_write),
        .l2_req_addr    (l2_req_addr),
        .l2_req_wdata   (l2_req_wdata),
        .l2_ack         (l2_ack),
        .l2_rdata       (l2_rdata),
        .ln_rd_idx      (rd_idx),
        .ln_valid       (rd_valid),
        .ln_dirty       (rd_dirty),
        .ln_tag         (rd_tag),
        .ln_data        (rd_data),
        .ln_wr_en       (wr_en),
        .ln_wr_idx      (wr_idx),
        .ln_wr_valid    (wr_valid),
        .ln_wr_dirty    (wr_dirty),
        .ln_wr_tag      (wr_tag),
        .ln_wr_data     (wr_data),
        .ln_valid_vec   (valid_vec),
        .ln_dirty_vec   (dirty_vec)
    );

    l1rc_lines #(
        .NUM_LINES (NUM_LINES),
        .TAG_W     (TAG_W),
        .DATA_W    (DATA_W)
    ) u_lines (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx    (rd_idx),
        .rd_valid  (rd_valid),
        .rd_dirty  (rd_dirty),
        .rd_tag    (rd_tag),
        .rd_data   (rd_data),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_valid  (wr_valid),
        .wr_dirty  (wr_dirty),
        .wr_tag    (wr_tag),
        .wr_data   (wr_data),
        .valid_vec (valid_vec),
        .dirty_vec (dirty_vec)
    );

endmodule

// File: tb/l1rc_tb.sv
`timescale 1ns/1ps
module l1rc_tb;

    localparam int AW = 6;
    localparam int DW = 8;
    localparam int NL = 4;
    localparam int LAT = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_kind = 2'b00;
    logic          req_gpu = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic          l2_valid, l2_write;
    logic [AW-1:0] l2_addr;
    logic [DW-1:0] l2_wdata;
    logic          l2_ack = 1'b0;
    logic [DW-1:0] l2_rdata = '0;

    int n_chk = 0, n_fail = 0, ready_bad = 0, stab_bad = 0, wcnt = 0;
    logic [DW-1:0] mem [64];
    int            log_n = 0;
    logic          log_wr   [256];
    logic [AW-1:0] log_addr [256];
    logic [DW-1:0] log_data [256];
    logic [AW-1:0] hold_addr;
    logic          hold_wr;
    logic [DW-1:0] hold_data;

    always #4 clk = ~clk;

    l1rc #(.ADDR_W(AW), .DATA_W(DW), .NUM_LINES(NL)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .core_req_valid(req_valid), .core_req_ready(req_ready),
        .core_req_kind(req_kind), .core_req_gpu(req_gpu),
        .core_req_addr(req_addr), .core_req_wdata(req_wdata),
        .core_rsp_valid(rsp_valid), .core_rsp_rdata(rsp_rdata),
        .l2_req_valid(l2_valid), .l2_req_write(l2_write),
        .l2_req_addr(l2_addr), .l2_req_wdata(l2_wdata),
        .l2_ack(l2_ack), .l2_rdata(l2_rdata)
    );

    function automatic logic [DW-1:0] init_val(input int a);
        return DW'((a * 37 + 11) & 8'hFF);
    endfunction

    // L2 model: fixed wait, one-cycle acknowledge, records every transfer
    always @(negedge clk) begin
        if (!rst_n) begin
            l2_ack = 1'b0;
            wcnt = 0;
        end else if (l2_ack) begin
            l2_ack = 1'b0;
            wcnt = 0;
        end else if (l2_valid) begin
            if (wcnt == 0) begin
                hold_addr = l2_addr; hold_wr = l2_write; hold_data = l2_wdata;
            end else if (l2_addr != hold_addr || l2_write != hold_wr
                         || (l2_write && l2_wdata != hold_data)) begin
                stab_bad++;
            end
            wcnt++;
            if (wcnt >= LAT) begin
                if (l2_write) mem[l2_addr] = l2_wdata;
                else          l2_rdata = mem[l2_addr];
                log_wr[log_n] = l2_write;
                log_addr[log_n] = l2_addr;
                log_data[log_n] = l2_write ? l2_wdata : mem[l2_addr];
                log_n++;
                l2_ack = 1'b1;
            end
        end
    end

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic chk_log(input int i, input logic wr, input int a, input int d,
                           input string rq);
        chk(log_n > i, rq, "transfer present", log_n, i + 1);
        if (log_n > i) begin
            chk(log_wr[i] == wr, rq, "transfer direction", int'(log_wr[i]), int'(wr));
            chk(int'(log_addr[i]) == a, rq, "transfer address", int'(log_addr[i]), a);
            chk(int'(log_data[i]) == d, rq, "transfer data", int'(log_data[i]), d);
        end
    endtask

    task automatic do_op(input logic [1:0] k, input logic g, input int a,
                         input int d, output int r);
        int cyc;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        log_n = 0;
        req_valid = 1'b1; req_kind = k; req_gpu = g;
        req_addr = AW'(a); req_wdata = DW'(d);
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 0;
        while (!rsp_valid && cyc < 2000) begin
            if (req_ready) ready_bad++;
            @(negedge clk);
            cyc++;
        end
        chk(rsp_valid, "R9", "response arrives", int'(rsp_valid), 1);
        r = int'(rsp_rdata);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R9 watchdog expired: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int r;
        for (int a = 0; a < 64; a++) mem[a] = init_val(a);
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(req_ready == 1'b1, "R1", "ready after reset", int'(req_ready), 1);
        chk(rsp_valid == 1'b0, "R1", "no response after reset", int'(rsp_valid), 0);
        chk(l2_valid == 1'b0, "R1", "no L2 request after reset", int'(l2_valid), 0);
        rst_n = 1'b1;

        // R1 R2 sweep: every address misses once, then hits
        for (int a = 0; a < 64; a++) begin
            do_op(2'b00, 1'b0, a, 0, r);
            chk(r == int'(init_val(a)), "R2", "miss data", r, int'(init_val(a)));
            chk(log_n == 1, "R1", "first load fetches", log_n, 1);
            chk_log(0, 1'b0, a, int'(init_val(a)), "R2");
            do_op(2'b00, 1'b0, a, 0, r);
            chk(r == int'(init_val(a)), "R2", "hit data", r, int'(init_val(a)));
            chk(log_n == 0, "R2", "hit is quiet", log_n, 0);
        end

        // R3 local stores
        do_op(2'b01, 1'b0, 61, 'hA1, r);
        chk(log_n == 0, "R3", "store hit quiet", log_n, 0);
        do_op(2'b00, 1'b0, 61, 0, r);
        chk(r == 'hA1, "R3", "store hit readback", r, 'hA1);
        do_op(2'b01, 1'b0, 6, 'hC6, r);
        chk(log_n == 0, "R3", "store miss clean victim quiet", log_n, 0);
        do_op(2'b00, 1'b0, 6, 0, r);
        chk(r == 'hC6, "R3", "store miss readback", r, 'hC6);

        // R4 dirty victims
        do_op(2'b01, 1'b0, 5, 'hB5, r);
        chk(log_n == 1, "R4", "store victim count", log_n, 1);
        chk_log(0, 1'b1, 61, 'hA1, "R4");
        do_op(2'b00, 1'b0, 9, 0, r);
        chk(log_n == 2, "R4", "load victim count", log_n, 2);
        chk_log(0, 1'b1, 5, 'hB5, "R4");
        chk_log(1, 1'b0, 9, int'(init_val(9)), "R4");
        chk(r == int'(init_val(9)), "R4", "load after evict", r, int'(init_val(9)));

        // R8 thread-group scope sync is plain access
        do_op(2'b11, 1'b0, 63, 'hD3, r);
        chk(log_n == 0, "R8", "group release quiet", log_n, 0);
        do_op(2'b10, 1'b0, 60, 0, r);
        chk(log_n == 0, "R8", "group acquire hit quiet", log_n, 0);
        chk(r == int'(init_val(60)), "R8", "group acquire data", r, int'(init_val(60)));
        do_op(2'b11, 1'b0, 12, 'hEC, r);
        chk(log_n == 0, "R8", "group release miss quiet", log_n, 0);

        // R5 device release: dirty lines at idx 0,2,3 then own line
        do_op(2'b11, 1'b1, 1, 'h77, r);
        chk(log_n == 4, "R5", "release transfer count", log_n, 4);
        chk_log(0, 1'b1, 12, 'hEC, "R5");
        chk_log(1, 1'b1, 6, 'hC6, "R5");
        chk_log(2, 1'b1, 63, 'hD3, "R5");
        chk_log(3, 1'b1, 1, 'h77, "R5");

        // R6 R7 device acquire of a present clean block
        do_op(2'b01, 1'b0, 6, 'h5A, r);
        mem[12] = 8'h99;
        do_op(2'b10, 1'b1, 12, 0, r);
        chk(r == 'h99, "R6", "acquire returns fresh data", r, 'h99);
        chk(log_n == 2, "R7", "acquire transfer count", log_n, 2);
        chk_log(0, 1'b0, 12, 'h99, "R6");
        chk_log(1, 1'b1, 6, 'h5A, "R7");
        do_op(2'b00, 1'b0, 63, 0, r);
        chk(log_n == 1, "R6", "other line invalidated", log_n, 1);
        chk(r == 'hD3, "R6", "refetch after invalidate", r, 'hD3);
        do_op(2'b00, 1'b0, 1, 0, r);
        chk(log_n == 1 && r == 'h77, "R6", "released word refetched", r, 'h77);
        do_op(2'b00, 1'b0, 6, 0, r);
        chk(log_n == 1 && r == 'h5A, "R7", "written-back word kept", r, 'h5A);
        do_op(2'b00, 1'b0, 12, 0, r);
        chk(log_n == 0, "R6", "acquired block stays", log_n, 0);
        chk(r == 'h99, "R6", "acquired block data", r, 'h99);

        // R7 acquire of its own dirty block
        do_op(2'b01, 1'b0, 12, 'h42, r);
        do_op(2'b10, 1'b1, 12, 0, r);
        chk(log_n == 2, "R7", "own dirty acquire count", log_n, 2);
        chk_log(0, 1'b1, 12, 'h42, "R7");
        chk_log(1, 1'b0, 12, 'h42, "R7");
        chk(r == 'h42, "R7", "own dirty acquire data", r, 'h42);

        chk(ready_bad == 0, "R9", "ready low while busy", ready_bad, 0);
        chk(stab_bad == 0, "R10", "L2 request held", stab_bad, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule